// File: doc/BRIEF.md
# Target-Only Programmed-IO Responder

This block is the application end of an endpoint that only ever answers. A host-issued load or store arrives as a request descriptor on a valid/ready receive stream. The block services it against on-chip storage split into four regions of 512 dwords (2 KB each, 8 KB in all). The region is picked by a 3-bit BAR identifier in the descriptor. Stores update local dwords and, for memory space, produce nothing in return. Loads, and I/O stores, produce a completion on a valid/ready transmit stream. The block never starts a transaction of its own.

A plain control input, `dword_mode`, chooses between two acceptance profiles. With it low, only single-dword requests are accepted, to 32-bit or 64-bit memory space or to I/O space. With it high, memory requests of 1 to 256 dwords to 32-bit memory space are accepted. A request that fails its profile is consumed and has no effect.

Back-pressure rules: a beat moves on either stream only in a cycle where valid and ready are both high. While the completion stream holds a beat, `cpl_valid` stays high and `cpl_hdr`, `cpl_data` and `cpl_last` stay unchanged until `cpl_ready` is seen. The receive stream is stalled (`rq_ready` low) for as long as a completion is being offered, so a slow consumer never causes a request to be lost.

Top module: `pio_target`

## Requirements
- R1: The BAR identifier sits at descriptor bits [114:112]. Values 0 to 3 select one of four independent 512-dword regions. Values 4 to 7 cause the request to be consumed with no write and no completion.
- R2: The dword index inside a region is address bits [10:2]; all higher address bits are ignored, so aliased addresses reach the same dword. A multi-dword access steps the index by one per dword and wraps modulo 512 within its region.
- R3: With `dword_mode` low, only requests whose dword count is exactly 1 are accepted, to memory space (32-bit or 64-bit) or to I/O space; any other count is dropped.
- R4: With `dword_mode` high, memory requests with a dword count of 1 to 256 and 32-bit addressing are accepted; I/O requests, 64-bit addressed requests and counts of 0 or above 256 are dropped.
- R5: A memory write updates its dwords and produces no completion. On the first dword, byte enable bit i (descriptor bits [119:116]) gates byte lane i. Later dwords are written in full.
- R6: A memory read returns one completion beat per requested dword, carrying consecutive local dwords, with `cpl_last` on the final beat and the with-data flag (header bit 30) set.
- R7: An accepted I/O write updates its dword like a memory write and returns one completion beat with the with-data flag clear, a dword-count field of 0, zero data and `cpl_last` high.
- R8: An accepted I/O read returns one completion beat with data from the addressed dword.
- R9: Completion header: [15:0] requester ID, [23:16] tag, [26:24] traffic class, all copied from the request; [29:27] status, always 0 (success); [30] with-data; [40:32] dword count; [45:41] address bits [6:2]; all other bits 0.
- R10: While `cpl_valid` is high and `cpl_ready` low, the offered beat (`cpl_valid`, `cpl_hdr`, `cpl_data`, `cpl_last`) holds unchanged into the next cycle.
- R11: `rq_ready` is low in every cycle in which `cpl_valid` is high. Requests are serviced in arrival order.
- R12: During reset and right after it, `cpl_valid` is low and `rq_ready` is high.
- R13: Request descriptor fields: [63:0] byte address, [74:64] dword count, [78:75] type (0 memory read, 1 memory write, 2 I/O read, 3 I/O write, others dropped), [79] 64-bit addressing flag, [95:80] requester ID, [103:96] tag, [122:120] traffic class. All bits not listed are ignored.
- R14: A request spans beats up to and including the beat with `rq_last`; write payload dwords come one per beat in `rq_data[31:0]`. A read that does not end on its first beat is consumed up to `rq_last` and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dword_mode | input | 1 | Acceptance profile: 0 single-dword, 1 multi-dword memory |
| rq_valid | input | 1 | Request beat valid |
| rq_ready | output | 1 | Request beat accepted when high with `rq_valid` |
| rq_desc | input | 128 | Request descriptor, sampled on the first beat |
| rq_data | input | 32 | Write payload dword for this beat |
| rq_last | input | 1 | Final beat of the request |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_hdr | output | 64 | Completion header, constant across a completion's beats |
| cpl_data | output | 32 | Completion payload dword |
| cpl_last | output | 1 | Final beat of the completion |

## Verification
The bench fills every region in multi-dword mode, then aims at the edges. These are a write that crosses index 511, an address with high bits set that must alias, a partial byte-enable write, and BAR values 4 to 7. A design that wraps into the next region or decodes the upper address bits returns the wrong dwords. One that truncates the BAR to two bits corrupts a live region. Each drop rule of both profiles is then exercised, followed by a read-back of the untouched dwords, and a stray completion or a changed value exposes a filter that is too permissive. The consumer then stalls at random while a further request is queued behind a long read. An engine that accepts requests during a completion, or lets the offered beat change, shows up as reordered or missing data.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int DESC_W = 128;
  localparam int HDR_W  = 64;
  localparam int DW_W   = 32;

  // request descriptor field positions
  localparam int F_ADDR_LO = 0;
  localparam int F_CNT_LO  = 64;
  localparam int F_CNT_W   = 11;
  localparam int F_TYPE_LO = 75;
  localparam int F_A64     = 79;
  localparam int F_RID_LO  = 80;
  localparam int F_TAG_LO  = 96;
  localparam int F_BAR_LO  = 112;
  localparam int F_BE_LO   = 116;
  localparam int F_TC_LO   = 120;

  // completion header field positions
  localparam int H_RID_LO  = 0;
  localparam int H_TAG_LO  = 16;
  localparam int H_TC_LO   = 24;
  localparam int H_STAT_LO = 27;
  localparam int H_WD      = 30;
  localparam int H_CNT_LO  = 32;
  localparam int H_CNT_W   = 9;
  localparam int H_LA_LO   = 41;

  localparam logic [2:0] CPL_STATUS_OK = 3'b000;

  typedef enum logic [2:0] {
    OP_MRD  = 3'd0,
    OP_MWR  = 3'd1,
    OP_IORD = 3'd2,
    OP_IOWR = 3'd3,
    OP_NONE = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WR   = 3'd1,
    S_RD   = 3'd2,
    S_IOWC = 3'd3,
    S_SKIP = 3'd4
  } st_e;

  typedef struct packed {
    op_e                op;
    logic [15:0]        dwi;   // byte address bits [17:2]
    logic [F_CNT_W-1:0] cnt;
    logic [15:0]        rid;
    logic [7:0]         tag;
    logic [2:0]         bar;
    logic [3:0]         be;
    logic [2:0]         tc;
  } req_t;

endpackage

// File: rtl/pio_req_decode.sv
module pio_req_decode
  import pio_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int MAX_DWORDS  = 256
) (
  input  logic [DESC_W-1:0] desc,
  input  logic              last,
  input  logic              dword_mode,
  output req_t              req,
  output logic              ok
);

  logic [3:0] code;
  logic       a64;
  logic       is_rd;
  logic       is_io;
  logic       bar_ok;
  logic       cnt_ok;
  logic       space_ok;
  logic       shape_ok;

  always_comb begin
    code = desc[F_TYPE_LO +: 4];
    a64  = desc[F_A64];

    case (code)
      4'd0:    req.op = OP_MRD;
      4'd1:    req.op = OP_MWR;
      4'd2:    req.op = OP_IORD;
      4'd3:    req.op = OP_IOWR;
      default: req.op = OP_NONE;
    endcase

    req.dwi = desc[F_ADDR_LO + 2 +: 16];
    req.cnt = desc[F_CNT_LO +: F_CNT_W];
    req.rid = desc[F_RID_LO +: 16];
    req.tag = desc[F_TAG_LO +: 8];
    req.bar = desc[F_BAR_LO +: 3];
    req.be  = desc[F_BE_LO +: 4];
    req.tc  = desc[F_TC_LO +: 3];

    is_rd = (req.op == OP_MRD) || (req.op == OP_IORD);
    is_io = (req.op == OP_IORD) || (req.op == OP_IOWR);

    bar_ok = int'(req.bar) < NUM_REGIONS;
    if (dword_mode) begin
      cnt_ok   = (req.cnt != '0) && (int'(req.cnt) <= MAX_DWORDS);
      space_ok = !is_io && !a64;
    end else begin
      cnt_ok   = (req.cnt == F_CNT_W'(1));
      space_ok = 1'b1;
    end
    shape_ok = !is_rd || last;

    ok = (req.op != OP_NONE) && bar_ok && cnt_ok && space_ok && shape_ok;
  end

endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int DWORDS = 512,
  parameter int IDX_W  = $clog2(DWORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [3:0]       wbe,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);

  logic [31:0] mem [DWORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 4; b++) begin
        if (wbe[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/pio_cpl_fmt.sv
module pio_cpl_fmt
  import pio_pkg::*;
(
  input  req_t             cur,
  input  logic             with_data,
  output logic [HDR_W-1:0] hdr
);

  always_comb begin
    hdr = '0;
    hdr[H_RID_LO +: 16]       = cur.rid;
    hdr[H_TAG_LO +: 8]        = cur.tag;
    hdr[H_TC_LO +: 3]         = cur.tc;
    hdr[H_STAT_LO +: 3]       = CPL_STATUS_OK;
    hdr[H_WD]                 = with_data;
    hdr[H_CNT_LO +: H_CNT_W]  = with_data ? cur.cnt[H_CNT_W-1:0] : '0;
    hdr[H_LA_LO +: 5]         = cur.dwi[4:0];
  end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rq_valid,
  input  logic             rq_last,
  input  logic [31:0]      rq_data,
  input  req_t             dec,
  input  logic             dec_ok,
  output logic             rq_ready,
  input  logic             cpl_ready,
  output logic             cpl_valid,
  output logic             cpl_last,
  output logic             cpl_with_data,
  output req_t             cur,
  output logic             wr_en,
  output logic [SEL_W-1:0] wr_sel,
  output logic [IDX_W-1:0] wr_idx,
  output logic [3:0]       wr_be,
  output logic [31:0]      wr_data,
  output logic [SEL_W-1:0] rd_sel,
  output logic [IDX_W-1:0] rd_idx
);

  st_e                state;
  logic [F_CNT_W-1:0] beat;
  logic               hs;
  logic [IDX_W-1:0]   cur_idx;

  assign cur_idx = cur.dwi[IDX_W-1:0];

  always_comb begin
    rq_ready      = (state == S_IDLE) || (state == S_WR) || (state == S_SKIP);
    hs            = rq_valid && rq_ready;
    cpl_valid     = (state == S_RD) || (state == S_IOWC);
    cpl_with_data = (state == S_RD);
    cpl_last      = (state == S_IOWC) || (beat == cur.cnt - F_CNT_W'(1));
    rd_sel        = cur.bar[SEL_W-1:0];
    rd_idx        = cur_idx + beat[IDX_W-1:0];

    wr_en   = 1'b0;
    wr_sel  = cur.bar[SEL_W-1:0];
    wr_idx  = cur_idx + beat[IDX_W-1:0];
    wr_be   = 4'hF;
    wr_data = rq_data;
    case (state)
      S_IDLE: begin
        if (hs && dec_ok && (dec.op == OP_MWR || dec.op == OP_IOWR)) begin
          wr_en  = 1'b1;
          wr_sel = dec.bar[SEL_W-1:0];
          wr_idx = dec.dwi[IDX_W-1:0];
          wr_be  = dec.be;
        end
      end
      S_WR:    wr_en = hs && (beat < cur.cnt);
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      beat  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (hs) begin
            cur <= dec;
            if (!dec_ok) begin
              state <= rq_last ? S_IDLE : S_SKIP;
            end else begin
              case (dec.op)
                OP_MWR: begin
                  beat  <= F_CNT_W'(1);
                  state <= rq_last ? S_IDLE : S_WR;
                end
                OP_IOWR: begin
                  beat  <= F_CNT_W'(1);
                  state <= rq_last ? S_IOWC : S_WR;
                end
                OP_MRD, OP_IORD: begin
                  beat  <= '0;
                  state <= S_RD;
                end
                default: state <= rq_last ? S_IDLE : S_SKIP;
              endcase
            end
          end
        end
        S_WR: begin
          if (hs) begin
            beat <= beat + F_CNT_W'(1);
            if (rq_last) state <= (cur.op == OP_IOWR) ? S_IOWC : S_IDLE;
          end
        end
        S_RD: begin
          if (cpl_ready) begin
            if (cpl_last) state <= S_IDLE;
            else          beat  <= beat + F_CNT_W'(1);
          end
        end
        S_IOWC: begin
          if (cpl_ready) state <= S_IDLE;
        end
        S_SKIP: begin
          if (hs && rq_last) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pio_target.sv
module pio_target
  import pio_pkg::*;
#(
  parameter int NUM_REGIONS   = 4,
  parameter int REGION_DWORDS = 512,
  parameter int MAX_DWORDS    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dword_mode,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [DESC_W-1:0] rq_desc,
  input  logic [DW_W-1:0]   rq_data,
  input  logic              rq_last,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [HDR_W-1:0]  cpl_hdr,
  output logic [DW_W-1:0]   cpl_data,
  output logic              cpl_last
);

  localparam int IDX_W = $clog2(REGION_DWORDS);
  localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  req_t             dec;
  logic             dec_ok;
  req_t             cur;
  logic             with_data;
  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [IDX_W-1:0] wr_idx;
  logic [3:0]       wr_be;
  logic [31:0]      wr_data;
  logic [SEL_W-1:0] rd_sel;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      bank_rd [NUM_REGIONS];

  pio_req_decode #(
    .NUM_REGIONS (NUM_REGIONS),
    .MAX_DWORDS  (MAX_DWORDS)
  ) u_dec (
    .desc       (rq_desc),
    .last       (rq_last),
    .dword_mode (dword_mode),
    .req        (dec),
    .ok         (dec_ok)
  );

  pio_ctrl #(
    .IDX_W (IDX_W),
    .SEL_W (SEL_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .rq_valid      (rq_valid),
    .rq_last       (rq_last),
    .rq_data       (rq_data),
    .dec           (dec),
    .dec_ok        (dec_ok),
    .rq_ready      (rq_ready),
    .cpl_ready     (cpl_ready),
    .cpl_valid     (cpl_valid),
    .cpl_last      (cpl_last),
    .cpl_with_data (with_data),
    .cur           (cur),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_idx        (wr_idx),
    .wr_be         (wr_be),
    .wr_data       (wr_data),
    .rd_sel        (rd_sel),
    .rd_idx        (rd_idx)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    pio_bank #(
      .DWORDS (REGION_DWORDS),
      .IDX_W  (IDX_W)
    ) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_sel == SEL_W'(g))),
      .widx  (wr_idx),
      .wbe   (wr_be),
      .wdata (wr_data),
      .ridx  (rd_idx),
      .rdata (bank_rd[g])
    );
  end

  pio_cpl_fmt u_fmt (
    .cur       (cur),
    .with_data (with_data),
    .hdr       (cpl_hdr)
  );

  assign cpl_data = with_data ? bank_rd[rd_sel] : '0;

endmodule

// File: rtl/pio_target_chk.sv
module pio_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rq_ready,
  input logic        cpl_valid,
  input logic        cpl_ready,
  input logic [63:0] cpl_hdr,
  input logic [31:0] cpl_data,
  input logic        cpl_last
);

  assert_cpl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=>
      (cpl_valid && $stable(cpl_hdr) && $stable(cpl_data) && $stable(cpl_last)));

  assert_rx_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !rq_ready);

  assert_status_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_hdr[29:27] == 3'b000));

  assert_nodata_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_hdr[30]) |->
      (cpl_last && cpl_data == 32'h0 && cpl_hdr[40:32] == 9'h0));

  assert_data_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_hdr[30]) |-> (cpl_hdr[40:32] != 9'h0));

  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |-> (!cpl_valid && rq_ready));

endmodule

bind pio_target pio_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rq_ready  (rq_ready),
  .cpl_valid (cpl_valid),
  .cpl_ready (cpl_ready),
  .cpl_hdr   (cpl_hdr),
  .cpl_data  (cpl_data),
  .cpl_last  (cpl_last)
);

// File: tb/pio_target_tb.sv
module pio_target_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dword_mode;
  logic         rq_valid;
  logic         rq_ready;
  logic [127:0] rq_desc;
  logic [31:0]  rq_data;
  logic         rq_last;
  logic         cpl_valid;
  logic         cpl_ready;
  logic [63:0]  cpl_hdr;
  logic [31:0]  cpl_data;
  logic         cpl_last;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [63:0] hdr;
    logic [31:0] data;
    logic        last;
    string       r;
  } exp_t;

  exp_t         exp_q[$];
  logic [31:0]  ref_mem [4][512];
  logic [127:0] desc_noise = '0;
  bit           stall = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_target u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dword_mode (dword_mode),
    .rq_valid   (rq_valid),
    .rq_ready   (rq_ready),
    .rq_desc    (rq_desc),
    .rq_data    (rq_data),
    .rq_last    (rq_last),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_hdr    (cpl_hdr),
    .cpl_data   (cpl_data),
    .cpl_last   (cpl_last)
  );

  // R13: descriptor layout built from the stated field positions
  function automatic logic [127:0] make_desc(int code, int bar, logic [63:0] addr, int cnt,
                                             bit a64, logic [15:0] rid, logic [7:0] tag,
                                             logic [3:0] be, logic [2:0] tc);
    logic [127:0] d;
    d = '0;
    d[63:0]    = addr;
    d[74:64]   = 11'(cnt);
    d[78:75]   = 4'(code);
    d[79]      = a64;
    d[95:80]   = rid;
    d[103:96]  = tag;
    d[114:112] = 3'(bar);
    d[119:116] = be;
    d[122:120] = tc;
    return d | desc_noise;
  endfunction

  // R9: completion header layout
  function automatic logic [63:0] exp_hdr(logic [15:0] rid, logic [7:0] tag, logic [2:0] tc,
                                          bit wd, int cnt, logic [63:0] addr);
    logic [63:0] h;
    h = '0;
    h[15:0]  = rid;
    h[23:16] = tag;
    h[26:24] = tc;
    h[30]    = wd;
    h[40:32] = wd ? 9'(cnt) : 9'h0;
    h[45:41] = addr[6:2];
    return h;
  endfunction

  task automatic send_beat(logic [127:0] d, logic [31:0] data, bit last);
    rq_valid = 1'b1;
    rq_desc  = d;
    rq_data  = data;
    rq_last  = last;
    @(negedge clk);
    while (!rq_ready) @(negedge clk);
    @(posedge clk);
    #1;
    rq_valid = 1'b0;
    rq_desc  = '0;
    rq_data  = '0;
    rq_last  = 1'b0;
  endtask

  task automatic do_write(int code, int bar, logic [63:0] addr, int cnt, int nbeats,
                          logic [3:0] be, bit a64, int seed, bit acc, string r);
    logic [127:0] d;
    logic [31:0]  data;
    int           idx;
    exp_t         e;
    d = make_desc(code, bar, addr, cnt, a64, 16'h0A0A, 8'(seed), be, 3'(seed));
    for (int k = 0; k < nbeats; k++) begin
      data = 32'(seed) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B9;
      send_beat((k == 0) ? d : 128'h0, data, k == nbeats - 1);
      if (acc && k < cnt) begin
        idx = (int'(addr[31:2]) + k) % 512;
        for (int b = 0; b < 4; b++)
          if (be[b] || k > 0) ref_mem[bar][idx][8*b +: 8] = data[8*b +: 8];
      end
    end
    if (acc && code == 3) begin
      e.hdr  = exp_hdr(16'h0A0A, 8'(seed), 3'(seed), 1'b0, 0, addr);
      e.data = '0;
      e.last = 1'b1;
      e.r    = r;
      exp_q.push_back(e);
    end
  endtask

  task automatic do_read(int code, int bar, logic [63:0] addr, int cnt, bit a64,
                         int tag, bit acc, string r);
    logic [15:0] rid;
    int          idx;
    exp_t        e;
    rid = 16'h1000 + 16'(tag);
    if (acc) begin
      for (int k = 0; k < cnt; k++) begin
        idx    = (int'(addr[31:2]) + k) % 512;
        e.hdr  = exp_hdr(rid, 8'(tag), 3'(tag), 1'b1, cnt, addr);
        e.data = ref_mem[bar][idx];
        e.last = (k == cnt - 1);
        e.r    = r;
        exp_q.push_back(e);
      end
    end
    send_beat(make_desc(code, bar, addr, cnt, a64, rid, 8'(tag), 4'hF, 3'(tag)), 32'h0, 1'b1);
  endtask

  task automatic drain(string r);
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d completion beats outstanding, expected 0", r, exp_q.size());
    end
    @(posedge clk);
    #1;
  endtask

  // consumer ready pattern
  initial begin
    cpl_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpl_ready = stall ? lfsr[0] : 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cpl_valid === 1'b1) begin
      checks++;
      if (rq_ready !== 1'b0) begin
        fails++;
        $display("FAIL R11: rq_ready %b while completion offered, expected 0", rq_ready);
      end
      if (cpl_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R5/R1: unexpected completion hdr %h data %h, expected none",
                   cpl_hdr, cpl_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (cpl_hdr !== e.hdr || cpl_data !== e.data || cpl_last !== e.last) begin
            fails++;
            $display("FAIL %s: hdr %h data %h last %b, expected hdr %h data %h last %b",
                     e.r, cpl_hdr, cpl_data, cpl_last, e.hdr, e.data, e.last);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    dword_mode = 1'b1;
    rq_valid   = 1'b0;
    rq_desc    = '0;
    rq_data    = '0;
    rq_last    = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cpl_valid !== 1'b0) begin
      fails++;
      $display("FAIL R12: cpl_valid %b in reset, expected 0", cpl_valid);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rq_ready !== 1'b1 || cpl_valid !== 1'b0) begin
      fails++;
      $display("FAIL R12: rq_ready %b cpl_valid %b after reset, expected 1 0", rq_ready, cpl_valid);
    end
    @(posedge clk);
    #1;

    // multi-dword profile: fill every region (R4, R5)
    for (int b = 0; b < 4; b++) begin
      do_write(1, b, 64'd0,    256, 256, 4'hF, 1'b0, 10 + b, 1'b1, "R4");
      do_write(1, b, 64'd1024, 256, 256, 4'hF, 1'b0, 20 + b, 1'b1, "R5");
    end
    do_read(0, 0, 64'd400, 256, 1'b0, 1, 1'b1, "R6");
    for (int b = 1; b < 4; b++) do_read(0, b, 64'd64, 8, 1'b0, 2 + b, 1'b1, "R1");
    drain("R6");

    // wrap from index 510 to 1 inside region 3 (R2)
    do_write(1, 3, 64'd2040, 4, 4, 4'hF, 1'b0, 40, 1'b1, "R2");
    do_read(0, 3, 64'd2040, 4, 1'b0, 9, 1'b1, "R2");

    // multi-dword profile drop rules (R4)
    do_write(3, 0, 64'd124, 1, 1, 4'hF, 1'b0, 50, 1'b0, "R4");
    do_write(1, 0, 64'd128, 1, 1, 4'hF, 1'b1, 51, 1'b0, "R4");
    do_write(1, 0, 64'd132, 0, 1, 4'hF, 1'b0, 52, 1'b0, "R4");
    do_read(0, 0, 64'd0, 257, 1'b0, 10, 1'b0, "R4");
    do_read(2, 0, 64'd0, 1, 1'b0, 11, 1'b0, "R4");
    do_read(0, 0, 64'd124, 3, 1'b0, 12, 1'b1, "R4");

    // read that spans two beats is dropped (R14)
    send_beat(make_desc(0, 0, 64'd0, 1, 1'b0, 16'h2222, 8'h22, 4'hF, 3'd2), 32'h0, 1'b0);
    send_beat(128'h0, 32'h0, 1'b1);
    do_read(0, 0, 64'd8, 1, 1'b0, 24, 1'b1, "R14");

    // BAR values above 3 are dropped (R1)
    do_write(1, 5, 64'd28, 1, 1, 4'hF, 1'b0, 60, 1'b0, "R1");
    do_read(0, 6, 64'd0, 1, 1'b0, 13, 1'b0, "R1");
    do_read(0, 1, 64'd28, 1, 1'b0, 14, 1'b1, "R1");
    drain("R1");

    // single-dword profile
    dword_mode = 1'b0;
    do_write(1, 2, 64'd20, 1, 1, 4'b0101, 1'b0, 70, 1'b1, "R5");
    do_read(0, 2, 64'd20, 1, 1'b0, 15, 1'b1, "R5");
    do_write(1, 1, 64'h0000_0001_0000_0810, 1, 1, 4'hF, 1'b1, 71, 1'b1, "R2");
    do_read(0, 1, 64'd16, 1, 1'b0, 16, 1'b1, "R2");
    do_write(1, 0, 64'd80, 2, 2, 4'hF, 1'b0, 72, 1'b0, "R3");
    do_read(0, 0, 64'd80, 1, 1'b0, 17, 1'b1, "R3");
    do_read(0, 0, 64'd0, 4, 1'b0, 18, 1'b0, "R3");
    do_read(0, 0, 64'h0000_0001_0000_0050, 1, 1'b1, 19, 1'b1, "R3");
    do_write(3, 0, 64'd120, 1, 1, 4'b1100, 1'b0, 73, 1'b1, "R7");
    do_read(2, 0, 64'd120, 1, 1'b0, 20, 1'b1, "R8");

    // ignored descriptor bits (R13)
    desc_noise = {5'b10101, 7'h0, 1'b1, 3'h0, 8'hA5, 104'h0};
    do_read(0, 3, 64'd8, 1, 1'b0, 21, 1'b1, "R13");
    desc_noise = '0;
    drain("R8");

    // back-pressure with a request queued behind a long read (R10, R11)
    dword_mode = 1'b1;
    stall      = 1'b1;
    do_read(0, 0, 64'd0, 32, 1'b0, 22, 1'b1, "R10");
    do_write(1, 0, 64'd0, 2, 2, 4'hF, 1'b0, 80, 1'b1, "R11");
    do_read(0, 0, 64'd0, 2, 1'b0, 23, 1'b1, "R11");
    drain("R10");
    stall = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule